// File: doc/BRIEF.md
# Dual-Bank General-Purpose I/O Controller

This block provides two eight-bit general-purpose I/O banks. Each bank keeps three registers: a direction mask (1 = input, 0 = output), a data register, and an inversion mask. An inversion bit flips the port value both on the way out to the pin and on the way back in from the pin. Software reaches the registers in two ways. The first is an indexed configuration path, where an index byte and a data byte arrive together with a read or write strobe. The second is a four-byte direct I/O window at a base address that software programs. The window exposes the direction and data registers of both banks.

An activation register gates the two banks. A disabled bank releases all of its pins, but its register contents stay as they were. Bit 0 of bank 1 is driven push-pull. Every other port is open-drain: it either pulls the pin low or releases it. Pin levels pass through a two-flop synchronizer before the inversion and readback logic uses them.

Top module: `gpio_dual_bank`

## Requirements
- R1: After reset, every direction register reads FFh, and the data registers, inversion registers, activation register and both base bytes read 00h. No output enable is asserted.
- R2: The configuration index map is as follows. Activation is at 30h. The base high byte is at 60h and the base low byte at 61h. Bank 1 direction, data and inversion are at F0h/F1h/F2h, and bank 2 uses F3h/F4h/F5h. A read of any other index returns 00h, and a write to any other index changes no register.
- R3: For an output bit (direction 0) in an enabled bank, the pin value equals data XOR inversion. An input bit never has its output enable asserted.
- R4: Reading a data register returns the stored data for output bits. For input bits it returns the synchronized pin XOR inversion. A pin change first shows in a read after the second rising clock edge.
- R5: Bank 1 bit 0 has its output enable asserted whenever it is an enabled output. Every other bit asserts its enable only when its driven value is 0. This means no open-drain port ever drives a 1.
- R6: Activation bit 0 enables both banks. When bit 0 is 0, bit 1 enables bank 1 and bit 2 enables bank 2.
- R7: A disabled bank deasserts all of its output enables. Its registers keep their contents and stay readable and writable through the configuration path.
- R8: The window base is {high byte, low byte} with its two low bits ignored. Address base+0 is bank 1 direction, base+1 is bank 1 data, base+2 is bank 2 direction and base+3 is bank 2 data. The window decodes only when the aligned base lies in 0100h to 0FFFh and the addressed bank is enabled.
- R9: A window read that does not decode returns FFh, and a window write that does not decode changes no register.
- R10: When a configuration write and a window write arrive in the same cycle, the configuration write takes effect and the window write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_rd_i | input | 1 | Configuration read strobe |
| cfg_idx_i | input | 8 | Configuration register index |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data (00h when not reading) |
| io_wr_i | input | 1 | Window write strobe |
| io_rd_i | input | 1 | Window read strobe |
| io_addr_i | input | 16 | Window address |
| io_wdata_i | input | 8 | Window write data |
| io_rdata_o | output | 8 | Window read data (FFh when not decoded) |
| pin_i | input | 16 | Pin levels, bank 2 in the upper byte |
| pin_o | output | 16 | Pin drive values |
| pin_oe_o | output | 16 | Pin output enables |

## Verification
The assertions check four rules on every cycle. A disabled bank never enables a pin. Input bits never drive. No open-drain port enables a driven 1. An undecoded window read returns FFh. The direction registers also stay stable in any cycle without a write strobe.

Some behaviour only the bench scenarios can show. These are the exact value mapping through inversion, the two-edge synchronizer latency, base alignment and range, the priority of a configuration write over a simultaneous window write, and the retention of register contents across disable. A shadow model of all registers runs beside the randomized traffic to check them.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned NBANK = 2;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] IDX_BANK0   = 8'hF0;

  typedef enum logic [1:0] {SEL_DIR = 2'd0, SEL_DATA = 2'd1, SEL_INV = 2'd2} reg_sel_e;

  function automatic logic [7:0] bank_idx(input int b, input reg_sel_e s);
    return IDX_BANK0 + 8'(3 * b) + 8'(s);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end
  assign q_o = sync_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] PP_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         dir_we_i,
  input  logic         data_we_i,
  input  logic         inv_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_sync_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] inv_o,
  output logic [W-1:0] rd_data_o,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o
);
  logic [W-1:0] dir_q, data_q, inv_q, val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      data_q <= '0;
      inv_q  <= '0;
    end else begin
      if (dir_we_i)  dir_q  <= wdata_i;
      if (data_we_i) data_q <= wdata_i;
      if (inv_we_i)  inv_q  <= wdata_i;
    end
  end

  assign val       = data_q ^ inv_q;
  assign rd_data_o = (dir_q & (pin_sync_i ^ inv_q)) | (~dir_q & data_q);
  assign pin_o     = val;
  // push-pull bits drive both levels; others only pull low
  assign pin_oe_o  = {W{en_i}} & ~dir_q & (PP_MASK | ~val);
  assign dir_o     = dir_q;
  assign inv_o     = inv_q;
endmodule

// File: rtl/gpio_win_dec.sv
module gpio_win_dec #(
  parameter int unsigned    AW      = 16,
  parameter logic [AW-1:0]  WIN_MIN = 16'h0100,
  parameter logic [AW-1:0]  WIN_MAX = 16'h0FFF
) (
  input  logic [AW-1:2] base_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    bank_en_i,
  output logic          hit_o,
  output logic          bank_o,
  output logic          is_data_o
);
  logic [AW-1:0] base_al;
  logic          in_range;
  assign base_al   = {base_i, 2'b00};
  assign in_range  = (base_al >= WIN_MIN) && (base_al <= WIN_MAX);
  assign bank_o    = addr_i[1];
  assign is_data_o = addr_i[0];
  assign hit_o     = in_range && (addr_i[AW-1:2] == base_i) && bank_en_i[addr_i[1]];
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_wr_i,
  input  logic                cfg_rd_i,
  input  logic [7:0]          cfg_idx_i,
  input  logic [7:0]          cfg_wdata_i,
  output logic [7:0]          cfg_rdata_o,
  input  logic                io_wr_i,
  input  logic                io_rd_i,
  input  logic [15:0]         io_addr_i,
  input  logic [7:0]          io_wdata_i,
  output logic [7:0]          io_rdata_o,
  input  logic [NBANK*W-1:0]  pin_i,
  output logic [NBANK*W-1:0]  pin_o,
  output logic [NBANK*W-1:0]  pin_oe_o
);
  localparam int unsigned PW = NBANK * W;

  logic [7:0]                act_q, base_hi_q, base_lo_q;
  logic [NBANK-1:0]          bank_en;
  logic [NBANK-1:0][W-1:0]   dir_q, inv_q, rd_q;
  logic [PW-1:0]             pin_sync;
  logic                      win_hit, win_bank, win_is_data, io_we;
  logic [W-1:0]              bank_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= '0;
      base_hi_q <= '0;
      base_lo_q <= '0;
    end else if (cfg_wr_i) begin
      if (cfg_idx_i == IDX_ACT)     act_q     <= cfg_wdata_i;
      if (cfg_idx_i == IDX_BASE_HI) base_hi_q <= cfg_wdata_i;
      if (cfg_idx_i == IDX_BASE_LO) base_lo_q <= cfg_wdata_i;
    end
  end

  gpio_sync #(.W(PW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_win_dec #(.AW(16)) u_dec (
    .base_i   ({base_hi_q, base_lo_q[7:2]}),
    .addr_i   (io_addr_i),
    .bank_en_i(bank_en),
    .hit_o    (win_hit),
    .bank_o   (win_bank),
    .is_data_o(win_is_data)
  );

  // configuration write wins over a same-cycle window write
  assign io_we      = io_wr_i && !cfg_wr_i && win_hit;
  assign bank_wdata = cfg_wr_i ? cfg_wdata_i : io_wdata_i;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [W-1:0] PP = (b == 0) ? W'(1) : '0;
    logic dir_we, data_we, inv_we;

    assign bank_en[b] = act_q[0] | act_q[1+b];
    assign dir_we  = (cfg_wr_i && cfg_idx_i == bank_idx(b, SEL_DIR)) ||
                     (io_we && win_bank == 1'(b) && !win_is_data);
    assign data_we = (cfg_wr_i && cfg_idx_i == bank_idx(b, SEL_DATA)) ||
                     (io_we && win_bank == 1'(b) && win_is_data);
    assign inv_we  = cfg_wr_i && cfg_idx_i == bank_idx(b, SEL_INV);

    gpio_bank #(.W(W), .PP_MASK(PP)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (bank_en[b]),
      .dir_we_i  (dir_we),
      .data_we_i (data_we),
      .inv_we_i  (inv_we),
      .wdata_i   (bank_wdata),
      .pin_sync_i(pin_sync[b*W +: W]),
      .dir_o     (dir_q[b]),
      .inv_o     (inv_q[b]),
      .rd_data_o (rd_q[b]),
      .pin_o     (pin_o[b*W +: W]),
      .pin_oe_o  (pin_oe_o[b*W +: W])
    );
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_rd_i) begin
      if (cfg_idx_i == IDX_ACT)     cfg_rdata_o = act_q;
      if (cfg_idx_i == IDX_BASE_HI) cfg_rdata_o = base_hi_q;
      if (cfg_idx_i == IDX_BASE_LO) cfg_rdata_o = base_lo_q;
      for (int b = 0; b < NBANK; b++) begin
        if (cfg_idx_i == bank_idx(b, SEL_DIR))  cfg_rdata_o = dir_q[b];
        if (cfg_idx_i == bank_idx(b, SEL_DATA)) cfg_rdata_o = rd_q[b];
        if (cfg_idx_i == bank_idx(b, SEL_INV))  cfg_rdata_o = inv_q[b];
      end
    end
  end

  assign io_rdata_o = (io_rd_i && win_hit) ?
                      (win_is_data ? rd_q[win_bank] : dir_q[win_bank]) : 8'hFF;
endmodule

// File: rtl/gpio_dual_bank_chk.sv
module gpio_dual_bank_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned NB = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NB-1:0]       bank_en,
  input logic [NB-1:0][W-1:0] dir_q,
  input logic [NB*W-1:0]     pin_o,
  input logic [NB*W-1:0]     pin_oe_o,
  input logic                cfg_wr_i,
  input logic                io_wr_i,
  input logic                io_rd_i,
  input logic                win_hit,
  input logic [7:0]          io_rdata_o
);
  localparam logic [NB*W-1:0] PP_ALL = (NB*W)'(1);

  // R7
  bank0_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_en[0] |-> pin_oe_o[W-1:0] == '0);
  // R7
  bank1_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_en[1] |-> pin_oe_o[2*W-1:W] == '0);
  // R3
  input_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & dir_q) == '0);
  // R5
  od_never_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & pin_o & ~PP_ALL) == '0);
  // R9
  miss_reads_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && !win_hit) |-> io_rdata_o == 8'hFF);
  // R2
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_wr_i && !io_wr_i) |=> $stable(dir_q));
endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(.W(W), .NB(gpio_pkg::NBANK)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bank_en   (bank_en),
  .dir_q     (dir_q),
  .pin_o     (pin_o),
  .pin_oe_o  (pin_oe_o),
  .cfg_wr_i  (cfg_wr_i),
  .io_wr_i   (io_wr_i),
  .io_rd_i   (io_rd_i),
  .win_hit   (win_hit),
  .io_rdata_o(io_rdata_o)
);

// File: tb/tb_gpio_dual_bank.sv
module tb_gpio_dual_bank;
  logic        clk_i = 0, rst_ni = 0;
  logic        cfg_wr_i = 0, cfg_rd_i = 0, io_wr_i = 0, io_rd_i = 0;
  logic [7:0]  cfg_idx_i = 0, cfg_wdata_i = 0, io_wdata_i = 0;
  logic [15:0] io_addr_i = 0, pin_i = 0;
  logic [7:0]  cfg_rdata_o, io_rdata_o;
  logic [15:0] pin_o, pin_oe_o;

  gpio_dual_bank dut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0]  m_dir [2], m_data [2], m_inv [2];
  logic [7:0]  m_act, m_hi, m_lo;
  logic [15:0] m_pin;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_en(input int b);
    return m_act[0] | m_act[1+b];
  endfunction

  function automatic logic [15:0] exp_o();
    return {m_data[1] ^ m_inv[1], m_data[0] ^ m_inv[0]};
  endfunction

  function automatic logic [15:0] exp_oe();
    logic [7:0] v0, v1, o0, o1;
    v0 = m_data[0] ^ m_inv[0];
    v1 = m_data[1] ^ m_inv[1];
    o0 = m_en(0) ? (~m_dir[0] & (8'h01 | ~v0)) : 8'h00;
    o1 = m_en(1) ? (~m_dir[1] & ~v1) : 8'h00;
    return {o1, o0};
  endfunction

  function automatic logic [7:0] exp_rd(input int b);
    logic [7:0] p;
    p = b ? m_pin[15:8] : m_pin[7:0];
    return (m_dir[b] & (p ^ m_inv[b])) | (~m_dir[b] & m_data[b]);
  endfunction

  function automatic bit m_hit(input logic [15:0] a);
    logic [15:0] base;
    base = {m_hi, m_lo[7:2], 2'b00};
    return base >= 16'h0100 && base <= 16'h0FFF && a[15:2] == base[15:2] && m_en(int'(a[1]));
  endfunction

  task automatic model_cfg(input logic [7:0] idx, input logic [7:0] d);
    case (idx)
      8'h30: m_act = d;
      8'h60: m_hi = d;
      8'h61: m_lo = d;
      8'hF0: m_dir[0] = d;
      8'hF1: m_data[0] = d;
      8'hF2: m_inv[0] = d;
      8'hF3: m_dir[1] = d;
      8'hF4: m_data[1] = d;
      8'hF5: m_inv[1] = d;
      default: ;
    endcase
  endtask

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk_i);
    cfg_wr_i = 1; cfg_idx_i = idx; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_wr_i = 0;
    model_cfg(idx, d);
  endtask

  task automatic cfg_read(input logic [7:0] idx, output logic [7:0] d);
    @(negedge clk_i);
    cfg_rd_i = 1; cfg_idx_i = idx;
    #1 d = cfg_rdata_o;
    cfg_rd_i = 0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    bit h;
    h = m_hit(a);
    @(negedge clk_i);
    io_wr_i = 1; io_addr_i = a; io_wdata_i = d;
    @(negedge clk_i);
    io_wr_i = 0;
    if (h) begin
      if (a[0]) m_data[a[1]] = d; else m_dir[a[1]] = d;
    end
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk_i);
    io_rd_i = 1; io_addr_i = a;
    #1 d = io_rdata_o;
    io_rd_i = 0;
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk_i);
    pin_i = v;
    repeat (2) @(negedge clk_i);
    m_pin = v;
  endtask

  task automatic check_pins(input string req);
    #1;
    check({req, " pin_o"}, pin_o, exp_o());
    check({req, " pin_oe"}, pin_oe_o, exp_oe());
  endtask

  initial begin
    logic [7:0] r;
    int unsigned seed;
    seed = $urandom(32'd4711);
    for (int b = 0; b < 2; b++) begin
      m_dir[b] = 8'hFF; m_data[b] = 0; m_inv[b] = 0;
    end
    m_act = 0; m_hi = 0; m_lo = 0; m_pin = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset values
    cfg_read(8'hF0, r); check("R1 dir1", 16'(r), 16'hFF);
    cfg_read(8'hF3, r); check("R1 dir2", 16'(r), 16'hFF);
    cfg_read(8'hF2, r); check("R1 inv1", 16'(r), 16'h00);
    cfg_read(8'hF4, r); check("R1 data2", 16'(r), 16'h00);
    cfg_read(8'h30, r); check("R1 act", 16'(r), 16'h00);
    cfg_read(8'h60, r); check("R1 base", 16'(r), 16'h00);
    check("R1 oe", pin_oe_o, 16'h0000);

    // R3 R5 output drive
    cfg_write(8'h30, 8'h01);
    cfg_write(8'hF1, 8'hA5);
    cfg_write(8'hF0, 8'h00);
    check_pins("R3");
    check("R5 oe low byte", 16'(pin_oe_o[7:0]), 16'h5B);
    cfg_write(8'hF2, 8'hFF);
    check_pins("R3 inv");
    check("R3 inverted", 16'(pin_o[7:0]), 16'h5A);
    cfg_read(8'hF1, r); check("R4 output readback", 16'(r), 16'hA5);

    // R4 input path latency and inversion
    cfg_write(8'hF5, 8'h0F);
    @(negedge clk_i); pin_i = 16'h3C00;
    @(negedge clk_i);
    cfg_rd_i = 1; cfg_idx_i = 8'hF4; #1 r = cfg_rdata_o; cfg_rd_i = 0;
    check("R4 one edge old", 16'(r), 16'h0F);
    m_pin = 16'h3C00;
    cfg_read(8'hF4, r); check("R4 after two edges", 16'(r), 16'h33);

    // R6 R7 activation
    cfg_write(8'hF3, 8'h00);
    cfg_write(8'h30, 8'h02);
    check_pins("R6 bank1 only");
    check("R7 bank2 off", 16'(pin_oe_o[15:8]), 16'h00);
    cfg_write(8'h30, 8'h04);
    check_pins("R6 bank2 only");
    cfg_read(8'hF1, r); check("R7 retained", 16'(r), 16'hA5);
    cfg_write(8'hF1, 8'h3C);
    cfg_read(8'hF1, r); check("R7 writable while off", 16'(r), 16'h3C);
    cfg_write(8'h30, 8'h01);

    // R2 unlisted index
    cfg_write(8'h10, 8'h55);
    cfg_read(8'h10, r); check("R2 unlisted", 16'(r), 16'h00);
    cfg_read(8'hF3, r); check("R2 untouched", 16'(r), 16'h00);

    // R8 R9 window
    cfg_write(8'h60, 8'h02);
    cfg_write(8'h61, 8'h00);
    io_write(16'h0201, 8'h0F);
    cfg_read(8'hF1, r); check("R8 win data1", 16'(r), 16'h0F);
    io_write(16'h0202, 8'hAA);
    cfg_read(8'hF3, r); check("R8 win dir2", 16'(r), 16'hAA);
    cfg_write(8'h61, 8'h03);
    io_read(16'h0200, r); check("R8 low bits ignored", 16'(r), 16'(m_dir[0]));
    io_read(16'h0203, r); check("R8 win data2", 16'(r), 16'(exp_rd(1)));
    io_read(16'h0204, r); check("R9 miss", 16'(r), 16'hFF);
    io_write(16'h0205, 8'h77);
    cfg_read(8'hF1, r); check("R9 miss write", 16'(r), 16'h0F);
    cfg_write(8'h30, 8'h02);
    io_read(16'h0202, r); check("R8 bank disabled", 16'(r), 16'hFF);
    cfg_write(8'h30, 8'h01);
    cfg_write(8'h60, 8'h00);
    cfg_write(8'h61, 8'h00);
    io_read(16'h0001, r); check("R8 below range", 16'(r), 16'hFF);
    cfg_write(8'h60, 8'h02);

    // R10 collision
    @(negedge clk_i);
    cfg_wr_i = 1; cfg_idx_i = 8'hF1; cfg_wdata_i = 8'h11;
    io_wr_i = 1; io_addr_i = 16'h0201; io_wdata_i = 8'h22;
    @(negedge clk_i);
    cfg_wr_i = 0; io_wr_i = 0; m_data[0] = 8'h11;
    cfg_read(8'hF1, r); check("R10 cfg wins", 16'(r), 16'(exp_rd(0)));

    // randomized traffic
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom % 5;
      case (op)
        0: begin
          logic [7:0] idx;
          idx = 8'hF0 + 8'($urandom % 6);
          cfg_write(idx, 8'($urandom));
        end
        1: begin
          logic [7:0] hs [3] = '{8'h01, 8'h02, 8'h0F};
          if ($urandom % 2) cfg_write(8'h60, hs[$urandom % 3]);
          else cfg_write(8'h61, 8'($urandom));
        end
        2: io_write({m_hi, m_lo[7:3], 3'($urandom)}, 8'($urandom));
        3: set_pins(16'($urandom));
        default: cfg_write(8'h30, 8'($urandom % 8));
      endcase
      check_pins("R5 random");
      cfg_read(8'hF1, r); check("R4 random bank1", 16'(r), 16'(exp_rd(0)));
      cfg_read(8'hF4, r); check("R4 random bank2", 16'(r), 16'(exp_rd(1)));
      begin
        logic [15:0] a;
        a = {m_hi, m_lo[7:3], 3'($urandom)};
        io_read(a, r);
        check("R9 random window read", 16'(r),
              m_hit(a) ? 16'(a[0] ? exp_rd(int'(a[1])) : m_dir[a[1]]) : 16'hFF);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule